// File: doc/BRIEF.md
# Wormhole Output-Queued Mesh Router

This block is a five-port router for a two-dimensional grid network-on-chip. It moves packets made of 32-bit flits between its North, East, South, West and Local ports by wormhole switching. The router holds no input storage. Each input steers its flit straight into the queue of the output that the packet's header names. A per-output round-robin arbiter picks which input may start a packet. That output then stays bound to the winning input until the packet's last flit has gone in.

Routing is by source route. The header flit carries a list of 3-bit output codes, and each router uses the lowest code and shifts the list down for the next hop. When an input cannot be served, because its output is bound to another packet or its output queue is full, the router drops ready toward the upstream neighbour. The waiting flit then stays in that neighbour's output queue. Routes are expected to obey an odd/even-row turn discipline that keeps the mesh free of deadlock. A bound checker flags any header that breaks the discipline for the router's configured row parity.

Top module: `wormhole_router`

## Requirements
- R1: After reset no output is valid, no input is ready while no input is valid, and every output arbiter's round-robin pointer starts at North (0).
- R2: A flit's type is in bits [31:30] (head 00, body 01, tail 10, single 11). In a head or single flit, bits [2:0] select the output: North 0, East 1, South 2, West 3, Local 4. The forwarded head or single has its route field (bits [29:0]) shifted right by 3 with zeros filling the top, and it appears on the output the cycle after it is accepted.
- R3: Once a head is accepted, its output is bound to that input. The input's body and tail flits go to the same output unchanged, whatever their low bits hold. Heads from other inputs for that output are not accepted (ready low) until the tail has been accepted.
- R4: An unbound output grants the first requesting input in the order pointer, pointer+1, … wrapping after Local. When a tail or single from input s is accepted, the pointer becomes s+1 (wrapping).
- R5: A single flit binds and releases its output in the same cycle, so a different waiting input can be accepted into that output on the next cycle.
- R6: Each output queue holds QDEPTH flits. While it is full, the input feeding it sees ready low. While an output is valid and not ready, its flit holds steady. No flit is lost or reordered.
- R7: Packets from different inputs to different outputs are accepted in the same cycle.
- R8: Turns are judged from travel direction: a flit entering on West travels east, one entering on South travels north, and so on. With ROW_ODD=0, West-in→South-out and South-in→West-out are forbidden. With ROW_ODD=1, South-in→East-out and East-in→South-out are forbidden. Permitted turns are forwarded, and a checker flags an accepted head that makes a forbidden turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 5 | Flit present on each input (N,E,S,W,L) |
| inFlit | input | 5x32 | Flit on each input |
| inReady | output | 5 | Flit on that input is accepted at this edge |
| outValid | output | 5 | Output queue holds a flit |
| outFlit | output | 5x32 | Flit at the head of each output queue |
| outReady | input | 5 | Downstream takes the output flit at this edge |

## Verification
The bench builds the router with QDEPTH=2, so a four-flit packet toward a stalled output fills its queue after two flits. This makes the upstream stall and the steady held flit visible within a few cycles. ROW_ODD=0 selects the even-row turn rules, so every permitted route the bench sends is judged against them. Arbitration is driven far enough that a second round starts mid-order, which shows the pointer rotation rather than a fixed priority.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NPORT  = 5;
  localparam int PIDX_W = 3;

  localparam logic [PIDX_W-1:0] P_NORTH = 3'd0;
  localparam logic [PIDX_W-1:0] P_EAST  = 3'd1;
  localparam logic [PIDX_W-1:0] P_SOUTH = 3'd2;
  localparam logic [PIDX_W-1:0] P_WEST  = 3'd3;
  localparam logic [PIDX_W-1:0] P_LOCAL = 3'd4;

  typedef enum logic [1:0] {
    FL_HEAD   = 2'd0,
    FL_BODY   = 2'd1,
    FL_TAIL   = 2'd2,
    FL_SINGLE = 2'd3
  } flit_kind_e;

  // strobes from control to datapath: which output queues take a flit, and from which input
  typedef struct packed {
    logic [NPORT-1:0]             push;
    logic [NPORT-1:0][PIDX_W-1:0] src;
  } xfer_strobe_t;

  // true when entering on inP and leaving on outP breaks the row-parity turn rule
  function automatic logic turnBanned(input logic [PIDX_W-1:0] inP,
                                      input logic [PIDX_W-1:0] outP,
                                      input logic rowOdd);
    if (!rowOdd)
      return (inP == P_WEST && outP == P_SOUTH) || (inP == P_SOUTH && outP == P_WEST);
    else
      return (inP == P_SOUTH && outP == P_EAST) || (inP == P_EAST && outP == P_SOUTH);
  endfunction
endpackage

// File: rtl/router_fifo.sv
module router_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic         full,
  output logic         notEmpty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;

  assign full     = (cnt == CW'(DEPTH));
  assign notEmpty = (cnt != '0);
  assign rdData   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/router_ctrl.sv
module router_ctrl import router_pkg::*; #(
  parameter int FLIT_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NPORT-1:0]                 inValid,
  input  logic [NPORT-1:0][FLIT_W-1:0]     inFlit,
  input  logic [NPORT-1:0]                 qFull,
  output logic [NPORT-1:0]                 inReady,
  output xfer_strobe_t                     strobe,
  output logic [NPORT-1:0]                 lockVec,
  output logic [NPORT-1:0][PIDX_W-1:0]     ownerVec
);
  logic [NPORT-1:0]             busy;
  logic [NPORT-1:0][PIDX_W-1:0] dest;
  logic [NPORT-1:0][PIDX_W-1:0] rrPtr;
  logic [NPORT-1:0][1:0]        kindVec;
  logic [NPORT-1:0][PIDX_W-1:0] code;
  logic [NPORT-1:0]             wantHead, wantBody;

  function automatic logic [PIDX_W-1:0] nextIdx(input logic [PIDX_W-1:0] s);
    return (s == PIDX_W'(NPORT-1)) ? '0 : s + 1'b1;
  endfunction

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      kindVec[i]  = inFlit[i][FLIT_W-1 -: 2];
      code[i]     = inFlit[i][PIDX_W-1:0];
      wantHead[i] = inValid[i] && !busy[i] &&
                    (kindVec[i] == FL_HEAD || kindVec[i] == FL_SINGLE);
      wantBody[i] = inValid[i] && busy[i];
    end
  end

  // per-output grant: bound owner first, otherwise round-robin over waiting heads
  logic              found;
  logic [PIDX_W-1:0] pick;
  int                idx;
  always_comb begin
    strobe = '0;
    found  = 1'b0;
    pick   = '0;
    idx    = 0;
    for (int o = 0; o < NPORT; o++) begin
      found = 1'b0;
      pick  = '0;
      if (lockVec[o]) begin
        pick  = ownerVec[o];
        found = wantBody[ownerVec[o]] && (dest[ownerVec[o]] == PIDX_W'(o));
      end else begin
        for (int k = 0; k < NPORT; k++) begin
          idx = int'(rrPtr[o]) + k;
          if (idx >= NPORT) idx = idx - NPORT;
          if (!found && wantHead[idx] && code[idx] == PIDX_W'(o)) begin
            found = 1'b1;
            pick  = PIDX_W'(idx);
          end
        end
      end
      strobe.push[o] = found && !qFull[o];
      strobe.src[o]  = pick;
    end
  end

  always_comb begin
    inReady = '0;
    for (int o = 0; o < NPORT; o++)
      if (strobe.push[o]) inReady[strobe.src[o]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= '0;
      dest     <= '0;
      rrPtr    <= '0;
      lockVec  <= '0;
      ownerVec <= '0;
    end else begin
      for (int o = 0; o < NPORT; o++) begin
        if (strobe.push[o]) begin
          case (kindVec[strobe.src[o]])
            FL_HEAD: begin
              lockVec[o]             <= 1'b1;
              ownerVec[o]            <= strobe.src[o];
              busy[strobe.src[o]]    <= 1'b1;
              dest[strobe.src[o]]    <= PIDX_W'(o);
            end
            FL_TAIL: begin
              lockVec[o]             <= 1'b0;
              busy[strobe.src[o]]    <= 1'b0;
              rrPtr[o]               <= nextIdx(strobe.src[o]);
            end
            FL_SINGLE: rrPtr[o]      <= nextIdx(strobe.src[o]);
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/router_dp.sv
module router_dp import router_pkg::*; #(
  parameter int FLIT_W = 32,
  parameter int QDEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0][FLIT_W-1:0] inFlit,
  input  xfer_strobe_t                 strobe,
  input  logic [NPORT-1:0]             outReady,
  output logic [NPORT-1:0]             outValid,
  output logic [NPORT-1:0][FLIT_W-1:0] outFlit,
  output logic [NPORT-1:0]             qFull
);
  genvar o;
  generate
    for (o = 0; o < NPORT; o++) begin : g_out
      logic [FLIT_W-1:0] chosen, wrData;
      logic [1:0]        kind;
      assign chosen = inFlit[strobe.src[o]];
      assign kind   = chosen[FLIT_W-1 -: 2];
      // head and single flits drop their leading route code for the next hop
      assign wrData = (kind == FL_HEAD || kind == FL_SINGLE)
                    ? {kind, {PIDX_W{1'b0}}, chosen[FLIT_W-3:PIDX_W]}
                    : chosen;

      router_fifo #(.W(FLIT_W), .DEPTH(QDEPTH)) u_q (
        .clk      (clk),
        .rst      (rst),
        .push     (strobe.push[o]),
        .pop      (outValid[o] && outReady[o]),
        .wrData   (wrData),
        .rdData   (outFlit[o]),
        .full     (qFull[o]),
        .notEmpty (outValid[o])
      );
    end
  endgenerate
endmodule

// File: rtl/wormhole_router.sv
module wormhole_router import router_pkg::*; #(
  parameter int FLIT_W  = 32,
  parameter int QDEPTH  = 4,
  parameter bit ROW_ODD = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0]             inValid,
  input  logic [NPORT-1:0][FLIT_W-1:0] inFlit,
  output logic [NPORT-1:0]             inReady,
  output logic [NPORT-1:0]             outValid,
  output logic [NPORT-1:0][FLIT_W-1:0] outFlit,
  input  logic [NPORT-1:0]             outReady
);
  xfer_strobe_t                 strobe;
  logic [NPORT-1:0]             qFull;
  logic [NPORT-1:0]             lockVec;
  logic [NPORT-1:0][PIDX_W-1:0] ownerVec;

  router_ctrl #(.FLIT_W(FLIT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inFlit   (inFlit),
    .qFull    (qFull),
    .inReady  (inReady),
    .strobe   (strobe),
    .lockVec  (lockVec),
    .ownerVec (ownerVec)
  );

  router_dp #(.FLIT_W(FLIT_W), .QDEPTH(QDEPTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .inFlit   (inFlit),
    .strobe   (strobe),
    .outReady (outReady),
    .outValid (outValid),
    .outFlit  (outFlit),
    .qFull    (qFull)
  );
endmodule

// File: rtl/router_check.sv
module router_check import router_pkg::*; #(
  parameter int FLIT_W  = 32,
  parameter bit ROW_ODD = 1'b0
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NPORT-1:0]             inValid,
  input logic [NPORT-1:0][FLIT_W-1:0] inFlit,
  input logic [NPORT-1:0]             inReady,
  input logic [NPORT-1:0]             outValid,
  input logic [NPORT-1:0][FLIT_W-1:0] outFlit,
  input logic [NPORT-1:0]             outReady,
  input logic [NPORT-1:0]             lockVec,
  input logic [NPORT-1:0][PIDX_W-1:0] ownerVec
);
  genvar o, i;
  generate
    for (o = 0; o < NPORT; o++) begin : g_o
      assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (outValid[o] && !outReady[o]) |=> (outValid[o] && $stable(outFlit[o])));

      assert_owner_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (lockVec[o] && $past(lockVec[o])) |-> $stable(ownerVec[o]));

      for (i = 0; i < NPORT; i++) begin : g_i
        logic accHere, headAcc, singleAcc;
        assign accHere   = inValid[i] && inReady[i] && (inFlit[i][PIDX_W-1:0] == PIDX_W'(o));
        assign headAcc   = accHere && (inFlit[i][FLIT_W-1 -: 2] == FL_HEAD);
        assign singleAcc = accHere && (inFlit[i][FLIT_W-1 -: 2] == FL_SINGLE);

        assert_head_locks_R3: assert property (@(posedge clk) disable iff (rst)
          headAcc |=> (lockVec[o] && ownerVec[o] == PIDX_W'(i)));

        assert_single_unlocked_R5: assert property (@(posedge clk) disable iff (rst)
          singleAcc |=> !lockVec[o]);

        if (turnBanned(PIDX_W'(i), PIDX_W'(o), ROW_ODD)) begin : g_ban
          assert_turn_legal_R8: assert property (@(posedge clk) disable iff (rst)
            !(headAcc || singleAcc));
        end
      end
    end
  endgenerate
endmodule

bind wormhole_router router_check #(.FLIT_W(FLIT_W), .ROW_ODD(ROW_ODD)) u_check (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inFlit   (inFlit),
  .inReady  (inReady),
  .outValid (outValid),
  .outFlit  (outFlit),
  .outReady (outReady),
  .lockVec  (lockVec),
  .ownerVec (ownerVec)
);

// File: tb/sim_wormhole_router.sv
module sim_wormhole_router;
  import router_pkg::*;
  localparam int W  = 32;
  localparam int NP = NPORT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NP-1:0]        inValid, inReady, outValid, outReady;
  logic [NP-1:0][W-1:0] inFlit, outFlit;

  wormhole_router #(.FLIT_W(W), .QDEPTH(2), .ROW_ODD(1'b0)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inFlit(inFlit), .inReady(inReady),
    .outValid(outValid), .outFlit(outFlit), .outReady(outReady));

  int nCheck = 0, nFail = 0, cyc = 0;
  bit done = 0;
  logic [W-1:0] gotQ [NP][$];
  int           gotT [NP][$];
  logic [W-1:0] expQ [NP][$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #2;
    if (!rst)
      for (int p = 0; p < NP; p++)
        if (outValid[p] && outReady[p]) begin
          gotQ[p].push_back(outFlit[p]);
          gotT[p].push_back(cyc);
        end
  end

  function automatic logic [W-1:0] mk(input logic [1:0] kind, input logic [W-3:0] fld);
    return {kind, fld};
  endfunction
  function automatic logic [W-3:0] rt(input int a, input int b, input int c);
    return (W-2)'(a) | ((W-2)'(b) << 3) | ((W-2)'(c) << 6);
  endfunction
  function automatic logic [W-1:0] fwd(input logic [W-1:0] f);
    return {f[W-1:W-2], 3'b000, f[W-3:3]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkStreams(input string req);
    for (int p = 0; p < NP; p++) begin
      check(gotQ[p].size() == expQ[p].size(), req, $sformatf("port %0d flit count", p),
            gotQ[p].size(), expQ[p].size());
      for (int k = 0; k < gotQ[p].size() && k < expQ[p].size(); k++)
        check(gotQ[p][k] == expQ[p][k], req, $sformatf("port %0d flit %0d", p, k),
              gotQ[p][k], expQ[p][k]);
      gotQ[p].delete(); gotT[p].delete(); expQ[p].delete();
    end
  endtask

  task automatic putFlit(input int i, input logic [W-1:0] f);
    logic ok;
    ok = 1'b0;
    @(negedge clk); #1;
    inValid[i] = 1'b1;
    inFlit[i]  = f;
    while (!ok) begin
      #2 ok = inReady[i];
      if (!ok) begin @(negedge clk); #1; end
    end
    @(posedge clk); #1;
    inValid[i] = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  // R1: quiet after reset
  task automatic testReset();
    @(negedge clk); #3;
    check(outValid == '0, "R1", "outValid after reset", outValid, 0);
    check(inReady == '0, "R1", "inReady with no input", inReady, 0);
  endtask

  // R2: route code selects output, header shifted, one-cycle latency
  task automatic testRoute();
    logic [W-1:0] s, h, b, t;
    s = mk(FL_SINGLE, rt(1, 2, 3));
    expQ[1].push_back(fwd(s));
    putFlit(4, s);
    @(negedge clk); #3;
    check(outValid[1] == 1'b1, "R2", "East valid one cycle after accept", outValid[1], 1);
    check(outFlit[1] == fwd(s), "R2", "shifted single", outFlit[1], fwd(s));
    h = mk(FL_HEAD, rt(2, 4, 0));
    b = mk(FL_BODY, 30'h1234567);
    t = mk(FL_TAIL, 30'h2abcdef);
    expQ[2].push_back(fwd(h)); expQ[2].push_back(b); expQ[2].push_back(t);
    putFlit(0, h); putFlit(0, b); putFlit(0, t);
    drain();
    checkStreams("R2");
  endtask

  // R3: output bound to a packet until its tail
  task automatic testLock();
    logic [W-1:0] h, b1, b2, t, e;
    logic ok;
    h  = mk(FL_HEAD, rt(2, 1, 1));
    b1 = mk(FL_BODY, 30'h5);
    b2 = mk(FL_BODY, 30'h1);
    t  = mk(FL_TAIL, 30'h3);
    e  = mk(FL_SINGLE, rt(2, 0, 0));
    expQ[2].push_back(fwd(h)); expQ[2].push_back(b1); expQ[2].push_back(b2);
    expQ[2].push_back(t); expQ[2].push_back(fwd(e));
    fork
      begin putFlit(0, h); putFlit(0, b1); putFlit(0, b2); putFlit(0, t); end
      begin
        @(negedge clk); @(negedge clk); #1;
        inValid[1] = 1'b1; inFlit[1] = e;
        #2 ok = inReady[1];
        check(ok == 1'b0, "R3", "other head held while bound", ok, 0);
        while (!ok) begin @(negedge clk); #3 ok = inReady[1]; end
        @(posedge clk); #1 inValid[1] = 1'b0;
      end
    join
    drain();
    checkStreams("R3");
  endtask

  // R4: round robin at packet boundaries, pointer rotation
  task automatic testRoundRobin();
    expQ[4].push_back(fwd(mk(FL_HEAD, rt(4, 0, 0)))); expQ[4].push_back(mk(FL_TAIL, 30'ha0));
    expQ[4].push_back(fwd(mk(FL_HEAD, rt(4, 1, 0)))); expQ[4].push_back(mk(FL_TAIL, 30'hb0));
    fork
      begin putFlit(0, mk(FL_HEAD, rt(4, 0, 0))); putFlit(0, mk(FL_TAIL, 30'ha0)); end
      begin putFlit(1, mk(FL_HEAD, rt(4, 1, 0))); putFlit(1, mk(FL_TAIL, 30'hb0)); end
    join
    drain();
    checkStreams("R4 first round");
    // pointer now 2: West, then North, then East
    expQ[4].push_back(fwd(mk(FL_HEAD, rt(4, 3, 3)))); expQ[4].push_back(mk(FL_TAIL, 30'hd3));
    expQ[4].push_back(fwd(mk(FL_HEAD, rt(4, 0, 0)))); expQ[4].push_back(mk(FL_TAIL, 30'hd0));
    expQ[4].push_back(fwd(mk(FL_HEAD, rt(4, 1, 1)))); expQ[4].push_back(mk(FL_TAIL, 30'hd1));
    fork
      begin putFlit(3, mk(FL_HEAD, rt(4, 3, 3))); putFlit(3, mk(FL_TAIL, 30'hd3)); end
      begin putFlit(0, mk(FL_HEAD, rt(4, 0, 0))); putFlit(0, mk(FL_TAIL, 30'hd0)); end
      begin putFlit(1, mk(FL_HEAD, rt(4, 1, 1))); putFlit(1, mk(FL_TAIL, 30'hd1)); end
    join
    drain();
    checkStreams("R4 rotated round");
  endtask

  // R5: single flits release the output in the same cycle
  task automatic testSingle();
    logic [W-1:0] a, c;
    a = mk(FL_SINGLE, rt(1, 4, 0));
    c = mk(FL_SINGLE, rt(1, 2, 0));
    expQ[1].push_back(fwd(a)); expQ[1].push_back(fwd(c));
    fork
      putFlit(0, a);
      putFlit(2, c);
    join
    drain();
    check(gotT[1].size() == 2, "R5", "two singles out", gotT[1].size(), 2);
    if (gotT[1].size() == 2)
      check(gotT[1][1] - gotT[1][0] == 1, "R5", "back-to-back cycle gap",
            gotT[1][1] - gotT[1][0], 1);
    checkStreams("R5");
  endtask

  // R6: full queue stalls the input, held flit stays
  task automatic testBackpressure();
    logic [W-1:0] h, b1, b2, t;
    h  = mk(FL_HEAD, rt(3, 2, 1));
    b1 = mk(FL_BODY, 30'h111);
    b2 = mk(FL_BODY, 30'h222);
    t  = mk(FL_TAIL, 30'h333);
    expQ[3].push_back(fwd(h)); expQ[3].push_back(b1); expQ[3].push_back(b2); expQ[3].push_back(t);
    outReady[3] = 1'b0;
    fork
      begin putFlit(1, h); putFlit(1, b1); putFlit(1, b2); putFlit(1, t); end
      begin
        repeat (4) @(negedge clk);
        #3;
        check(inReady[1] == 1'b0, "R6", "input stalled on full queue", inReady[1], 0);
        check(outValid[3] == 1'b1, "R6", "stalled output valid", outValid[3], 1);
        check(outFlit[3] == fwd(h), "R6", "held head flit", outFlit[3], fwd(h));
        @(negedge clk); #1 outReady[3] = 1'b1;
      end
    join
    drain();
    checkStreams("R6");
  endtask

  // R7: disjoint transfers in the same cycle
  task automatic testParallel();
    logic [W-1:0] a, b, c;
    a = mk(FL_SINGLE, rt(2, 0, 0));
    b = mk(FL_SINGLE, rt(3, 0, 0));
    c = mk(FL_SINGLE, rt(0, 1, 0));
    expQ[2].push_back(fwd(a)); expQ[3].push_back(fwd(b)); expQ[0].push_back(fwd(c));
    fork putFlit(0, a); putFlit(1, b); putFlit(4, c); join
    drain();
    if (gotT[2].size() == 1 && gotT[3].size() == 1 && gotT[0].size() == 1) begin
      check(gotT[2][0] == gotT[3][0], "R7", "S and W same cycle", gotT[3][0], gotT[2][0]);
      check(gotT[2][0] == gotT[0][0], "R7", "S and N same cycle", gotT[0][0], gotT[2][0]);
    end
    checkStreams("R7");
  endtask

  // R8: turns permitted in an even row are forwarded
  task automatic testTurns();
    logic [W-1:0] a, b;
    a = mk(FL_SINGLE, rt(0, 3, 0));
    b = mk(FL_SINGLE, rt(1, 1, 2));
    expQ[0].push_back(fwd(a)); expQ[1].push_back(fwd(b));
    fork putFlit(3, a); putFlit(2, b); join
    drain();
    checkStreams("R8");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
  endtask

  initial begin
    inValid = '0; inFlit = '0; outReady = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;
    testReset();
    testRoute();
    testLock();
    testRoundRobin();
    testSingle();
    testBackpressure();
    testParallel();
    testTurns();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCheck++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule